// File: doc/BRIEF.md
# Strobed Byte Port with Two-Line Handshake

This block is an 8-bit parallel port that moves bytes across a chip boundary under a two-line handshake. One line is an active-low "data present" strobe and the other is a "ready" line. The port acts either as a receiver, capturing bytes from an outside sender, or as a transmitter, offering bytes to an outside receiver. The role is chosen by the configured direction of the upper nibble of the port. While the handshake is on, the lower nibble is forced to the upper nibble's direction.

On the core side, a byte write interface carries a busy flag, and a byte read interface carries a valid flag that a read clears. Both incoming handshake lines pass through a two-flop synchronizer before the control logic looks at them. With default parameters, every response to an external line therefore appears on the third rising clock edge after that line changes.

Top module: `hsk_port`

## Requirements
- R1: During and straight after reset, rd_valid and wr_busy are 0, dav_n_out and rdy_out are 1, and pad_dout is 0x00.
- R2: A direction bit of 1 means input. pad_oe[7:4] equals the inverse of dir_hi_in. pad_oe[3:0] equals the inverse of dir_hi_in when hs_en is 1, and the inverse of dir_lo_in when hs_en is 0.
- R3: With hs_en=1 and dir_hi_in=1 (receive), rdy_oe=1 and dav_oe=0. With hs_en=1 and dir_hi_in=0 (transmit), dav_oe=1 and rdy_oe=0. With hs_en=0, both are 0.
- R4: In receive, rdy_out falls on the third rising edge after dav_n_in falls, and not before. On that same edge, pad_din is captured into rd_data and rd_valid is set.
- R5: In receive, rdy_out stays low while dav_n_in stays low. rdy_out returns high on the third rising edge after dav_n_in rises.
- R6: A one-cycle rd_en pulse clears rd_valid on the next edge. A byte that arrives before the last one is read replaces it, and rd_valid stays 1.
- R7: In transmit, an accepted write shows its byte on pad_dout and sets wr_busy on the next edge. dav_n_out falls one edge later if the synchronized ready is high. If ready is low, dav_n_out stays high until the third edge after rdy_in rises.
- R8: In transmit, dav_n_out returns high on the third rising edge after rdy_in falls.
- R9: wr_busy stays 1 until the third rising edge after rdy_in rises again following its fall. While wr_busy is 0, dav_n_out is 1.
- R10: A write while wr_busy is 1 is ignored: pad_dout keeps the byte in flight.
- R11: Writes are ignored unless the port is in transmit handshake mode (wr_busy stays 0 and pad_dout is unchanged). A falling dav_n_in is ignored unless the port is in receive handshake mode (rd_valid stays 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_en | input | 1 | Handshake mode enable |
| dir_hi_in | input | 1 | Upper nibble direction, 1 = input; selects receive or transmit |
| dir_lo_in | input | 1 | Lower nibble direction when handshake is off, 1 = input |
| pad_din | input | 8 | Port pin input data |
| pad_dout | output | 8 | Port pin output data |
| pad_oe | output | 8 | Per-bit output enable, 1 = drive |
| dav_n_in | input | 1 | Data-present strobe from an outside sender, active low |
| dav_n_out | output | 1 | Data-present strobe to an outside receiver, active low |
| dav_oe | output | 1 | Drive enable for the data-present line |
| rdy_in | input | 1 | Ready line from an outside receiver |
| rdy_out | output | 1 | Ready line to an outside sender |
| rdy_oe | output | 1 | Drive enable for the ready line |
| wr_en | input | 1 | Core write strobe |
| wr_data | input | 8 | Core write byte |
| wr_busy | output | 1 | Transmit handshake in progress |
| rd_en | input | 1 | Core read strobe, clears rd_valid |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | Received byte not yet read |

## Verification
The checker assumes the following about the port's inputs:
- The outside party obeys the protocol: pad_din is held stable from before dav_n_in falls until rdy_out goes low.
- hs_en and the direction bits are not changed while a transfer is under way.
- rdy_in and dav_n_in move only between handshake phases.

The bench drives every input on the falling clock edge. It reconfigures direction only when both state machines are idle. It moves each handshake line only after the previous response has been observed, so every stimulus stays within these assumptions.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [0:0] {
    RX_OPEN,
    RX_HELD
  } rx_st_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SETUP,
    TX_STROBE,
    TX_DRAIN
  } tx_st_t;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        assign chain_d[gi] = d;
      end else begin : g_next
        assign chain_d[gi] = chain_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hsk_rx.sv
module hsk_rx
  import hsk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              dav_s,
  input  logic [DATA_W-1:0] pad_din,
  input  logic              rd_en,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  rx_st_t            st_q, st_d;
  logic              dav_prev_q;
  logic              dav_fall;
  logic              cap_en;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q;

  assign dav_fall = dav_prev_q & ~dav_s;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    if (!active) begin
      st_d = RX_OPEN;
    end else begin
      case (st_q)
        RX_OPEN: if (dav_fall) begin
          st_d   = RX_HELD;
          cap_en = 1'b1;
        end
        RX_HELD: if (dav_s) st_d = RX_OPEN;
        default: st_d = RX_OPEN;
      endcase
    end
  end

  always_comb begin
    if (cap_en)     valid_d = 1'b1;
    else if (rd_en) valid_d = 1'b0;
    else            valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= RX_OPEN;
      dav_prev_q <= 1'b1;
      valid_q    <= 1'b0;
    end else begin
      st_q       <= st_d;
      dav_prev_q <= dav_s;
      valid_q    <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= pad_din;
  end

  assign rdy_o    = (st_q == RX_OPEN);
  assign rx_data  = data_q;
  assign rx_valid = valid_q;
endmodule

// File: rtl/hsk_tx.sv
module hsk_tx
  import hsk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rdy_s,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dav_n_o,
  output logic              busy
);
  tx_st_t            st_q, st_d;
  logic              load_en;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    if (!active) begin
      st_d = TX_IDLE;
    end else begin
      case (st_q)
        TX_IDLE: if (wr_en) begin
          st_d    = TX_SETUP;
          load_en = 1'b1;
        end
        TX_SETUP:  if (rdy_s)  st_d = TX_STROBE;
        TX_STROBE: if (!rdy_s) st_d = TX_DRAIN;
        TX_DRAIN:  if (rdy_s)  st_d = TX_IDLE;
        default:               st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TX_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (load_en) dout_q <= wr_data;
  end

  assign dout    = dout_q;
  assign dav_n_o = (st_q != TX_STROBE);
  assign busy    = (st_q != TX_IDLE);
endmodule

// File: rtl/hsk_port.sv
module hsk_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_en,
  input  logic              dir_hi_in,
  input  logic              dir_lo_in,
  input  logic [DATA_W-1:0] pad_din,
  output logic [DATA_W-1:0] pad_dout,
  output logic [DATA_W-1:0] pad_oe,
  input  logic              dav_n_in,
  output logic              dav_n_out,
  output logic              dav_oe,
  input  logic              rdy_in,
  output logic              rdy_out,
  output logic              rdy_oe,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_busy,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HALF = DATA_W / 2;
  localparam int UPPER = DATA_W - HALF;

  logic rx_active;
  logic tx_active;
  logic lo_dir_eff;
  logic dav_s;
  logic rdy_s;

  assign rx_active  = hs_en & dir_hi_in;
  assign tx_active  = hs_en & ~dir_hi_in;
  assign lo_dir_eff = hs_en ? dir_hi_in : dir_lo_in;

  assign pad_oe = {{UPPER{~dir_hi_in}}, {HALF{~lo_dir_eff}}};
  assign dav_oe = tx_active;
  assign rdy_oe = rx_active;

  hsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dav_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (dav_n_in),
    .q   (dav_s)
  );

  hsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (rdy_in),
    .q   (rdy_s)
  );

  hsk_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (rx_active),
    .dav_s    (dav_s),
    .pad_din  (pad_din),
    .rd_en    (rd_en),
    .rdy_o    (rdy_out),
    .rx_data  (rd_data),
    .rx_valid (rd_valid)
  );

  hsk_tx #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (tx_active),
    .rdy_s   (rdy_s),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dout    (pad_dout),
    .dav_n_o (dav_n_out),
    .busy    (wr_busy)
  );
endmodule

// File: rtl/hsk_port_chk.sv
module hsk_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_en,
  input logic [DATA_W-1:0] pad_dout,
  input logic [DATA_W-1:0] pad_oe,
  input logic              dav_n_out,
  input logic              dav_oe,
  input logic              rdy_out,
  input logic              rdy_oe,
  input logic              wr_busy,
  input logic              rd_valid
);
  localparam int HALF = DATA_W / 2;

  p_nibbles_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (pad_oe[HALF-1:0] == {HALF{pad_oe[DATA_W-1]}}));

  p_roles_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dav_oe && rdy_oe));

  p_rdy_fall_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_oe && $fell(rdy_out)) |-> rd_valid);

  p_strobe_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_n_out) |-> $stable(pad_dout));

  p_idle_strobe_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busy |-> dav_n_out);

  p_busy_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && $past(wr_busy)) |-> $stable(pad_dout));
endmodule

bind hsk_port hsk_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_en     (hs_en),
  .pad_dout  (pad_dout),
  .pad_oe    (pad_oe),
  .dav_n_out (dav_n_out),
  .dav_oe    (dav_oe),
  .rdy_out   (rdy_out),
  .rdy_oe    (rdy_oe),
  .wr_busy   (wr_busy),
  .rd_valid  (rd_valid)
);

// File: tb/tb_hsk_port.sv
module tb_hsk_port;
  logic       clk;
  logic       rst_n;
  logic       hs_en, dir_hi_in, dir_lo_in;
  logic [7:0] pad_din, pad_dout, pad_oe;
  logic       dav_n_in, dav_n_out, dav_oe;
  logic       rdy_in, rdy_out, rdy_oe;
  logic       wr_en, wr_busy, rd_en, rd_valid;
  logic [7:0] wr_data, rd_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  hsk_port dut (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .dir_hi_in(dir_hi_in),
    .dir_lo_in(dir_lo_in), .pad_din(pad_din), .pad_dout(pad_dout),
    .pad_oe(pad_oe), .dav_n_in(dav_n_in), .dav_n_out(dav_n_out),
    .dav_oe(dav_oe), .rdy_in(rdy_in), .rdy_out(rdy_out), .rdy_oe(rdy_oe),
    .wr_en(wr_en), .wr_data(wr_data), .wr_busy(wr_busy), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_byte(input logic [7:0] b, input bit do_read);
    pad_din = b;
    nedge(1);
    dav_n_in = 1'b0;
    nedge(2);
    chk(rdy_out == 1'b1, "R4 early", rdy_out, 1);
    nedge(1);
    chk(rdy_out == 1'b0, "R4 rdy", rdy_out, 0);
    chk(rd_valid == 1'b1, "R4 valid", rd_valid, 1);
    chk(rd_data == b, "R4 data", rd_data, b);
    nedge(2);
    chk(rdy_out == 1'b0, "R5 held", rdy_out, 0);
    dav_n_in = 1'b1;
    pad_din  = ~b;
    nedge(2);
    chk(rdy_out == 1'b0, "R5 early", rdy_out, 0);
    nedge(1);
    chk(rdy_out == 1'b1, "R5 release", rdy_out, 1);
    if (do_read) begin
      rd_en = 1'b1;
      nedge(1);
      rd_en = 1'b0;
      chk(rd_valid == 1'b0, "R6 clear", rd_valid, 0);
    end
  endtask

  task automatic tx_byte(input logic [7:0] b);
    wr_data = b;
    wr_en   = 1'b1;
    nedge(1);
    wr_en = 1'b0;
    chk(wr_busy == 1'b1, "R7 busy", wr_busy, 1);
    chk(pad_dout == b, "R7 data", pad_dout, b);
    chk(dav_n_out == 1'b1, "R7 setup", dav_n_out, 1);
    nedge(1);
    chk(dav_n_out == 1'b0, "R7 strobe", dav_n_out, 0);
    wr_data = ~b;
    wr_en   = 1'b1;
    nedge(1);
    wr_en = 1'b0;
    chk(pad_dout == b, "R10 reject", pad_dout, b);
    rdy_in = 1'b0;
    nedge(2);
    chk(dav_n_out == 1'b0, "R8 early", dav_n_out, 0);
    nedge(1);
    chk(dav_n_out == 1'b1, "R8 release", dav_n_out, 1);
    chk(wr_busy == 1'b1, "R9 drain", wr_busy, 1);
    rdy_in = 1'b1;
    nedge(2);
    chk(wr_busy == 1'b1, "R9 early", wr_busy, 1);
    nedge(1);
    chk(wr_busy == 1'b0, "R9 done", wr_busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; hs_en = 1'b0; dir_hi_in = 1'b1; dir_lo_in = 1'b1;
    pad_din = 8'h00; dav_n_in = 1'b1; rdy_in = 1'b1;
    wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
    nedge(3);
    chk({rd_valid, wr_busy, dav_n_out, rdy_out} == 4'b0011, "R1 in reset",
        {rd_valid, wr_busy, dav_n_out, rdy_out}, 4'b0011);
    rst_n = 1'b1;
    nedge(1);
    chk({rd_valid, wr_busy, dav_n_out, rdy_out} == 4'b0011, "R1 after",
        {rd_valid, wr_busy, dav_n_out, rdy_out}, 4'b0011);
    chk(pad_dout == 8'h00, "R1 dout", pad_dout, 0);

    for (int cfg = 0; cfg < 8; cfg++) begin
      logic       e_hs, e_hi, e_lo, e_loeff;
      logic [7:0] e_oe;
      e_hs = cfg[2]; e_hi = cfg[1]; e_lo = cfg[0];
      hs_en = e_hs; dir_hi_in = e_hi; dir_lo_in = e_lo;
      nedge(1);
      e_loeff = e_hs ? e_hi : e_lo;
      e_oe = {{4{~e_hi}}, {4{~e_loeff}}};
      chk(pad_oe == e_oe, "R2 oe", pad_oe, e_oe);
      chk({dav_oe, rdy_oe} == {e_hs & ~e_hi, e_hs & e_hi}, "R3 roles",
          {dav_oe, rdy_oe}, {e_hs & ~e_hi, e_hs & e_hi});
    end

    hs_en = 1'b1; dir_hi_in = 1'b1; dir_lo_in = 1'b0;
    nedge(3);
    for (int i = 0; i < 8; i++) rx_byte(8'(i * 37 + 5), 1'b1);
    rx_byte(8'h5A, 1'b0);
    rx_byte(8'hA5, 1'b0);
    chk(rd_data == 8'hA5 && rd_valid, "R6 overwrite", rd_data, 8'hA5);
    rd_en = 1'b1; nedge(1); rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R6 read", rd_valid, 0);

    wr_data = 8'h3C; wr_en = 1'b1; nedge(1); wr_en = 1'b0;
    nedge(2);
    chk(wr_busy == 1'b0, "R11 wr in rx", wr_busy, 0);
    chk(pad_dout == 8'h00, "R11 dout", pad_dout, 0);

    dir_hi_in = 1'b0;
    nedge(3);
    for (int i = 0; i < 8; i++) tx_byte(8'(i * 53 + 11));

    rdy_in = 1'b0;
    nedge(3);
    wr_data = 8'hE7; wr_en = 1'b1; nedge(1); wr_en = 1'b0;
    chk(wr_busy == 1'b1 && pad_dout == 8'hE7, "R7 load", pad_dout, 8'hE7);
    nedge(2);
    chk(dav_n_out == 1'b1, "R7 wait rdy", dav_n_out, 1);
    rdy_in = 1'b1;
    nedge(2);
    chk(dav_n_out == 1'b1, "R7 rdy sync", dav_n_out, 1);
    nedge(1);
    chk(dav_n_out == 1'b0, "R7 late strobe", dav_n_out, 0);
    rdy_in = 1'b0; nedge(3);
    chk(dav_n_out == 1'b1, "R8 late", dav_n_out, 1);
    rdy_in = 1'b1; nedge(3);
    chk(wr_busy == 1'b0, "R9 late", wr_busy, 0);

    dav_n_in = 1'b0; nedge(4);
    chk(rd_valid == 1'b0, "R11 dav in tx", rd_valid, 0);
    dav_n_in = 1'b1;
    hs_en = 1'b0; nedge(1);
    wr_data = 8'h81; wr_en = 1'b1; nedge(1); wr_en = 1'b0;
    nedge(1);
    chk(wr_busy == 1'b0 && pad_dout == 8'hE7, "R11 wr off", pad_dout, 8'hE7);
    dav_n_in = 1'b0; nedge(4);
    chk(rd_valid == 1'b0, "R11 dav off", rd_valid, 0);
    dav_n_in = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule